// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and a 128K-word by 8-bit asynchronous static RAM. The host hands it one word at a time through a request/ready handshake. The block then produces the chip-select, write-strobe and output-enable sequence on the memory pins, and it controls when the shared data bus is driven. Every analog interval the memory needs is a nanosecond parameter. Elaboration converts each one to a whole number of clock cycles, so the same code serves any speed grade at any clock rate.

Reads select the chip with the output enable low and wait out the longer of the address access time and the output-enable access time. The returned byte is latched and then shown to the host for one cycle. After a read the block waits a turnaround interval with output enable high, so the memory's drivers are off before anyone drives the bus again. Writes place address and data first, then pulse the write strobe for a counted width. Data is held for a counted interval after the strobe rises. Output enable stays high for the whole write, so the bus never has to turn around inside a write. Between accesses the memory is deselected and sits in standby.

Cycle counts used below: `cyc(t)` is the smallest n with n × CLK_NS ≥ t, and 0 when t is 0. ACC = max(cyc(T_AA), cyc(T_DOE), 1). WAIT = max(ACC−2, 0). TA = max(cyc(T_HZOE), 1, cyc(T_RC) − WAIT − 2). PW = max(cyc(T_PWE), cyc(T_SD), cyc(T_AW) − 1, 1). HOLD = max(cyc(T_HD), 1, cyc(T_WC) − 1 − PW).

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset and whenever no access is in progress, the pins are mem_sel_n=1, mem_sel=0, mem_we_n=1 and mem_oe_n=1, with mem_dq_oe=0. In the same state ready=1 and rd_valid=0.
- R2: A write commits req_wdata at req_addr. While mem_we_n is 0, mem_sel_n is 0, mem_sel is 1, mem_oe_n is 1 and the bus is driven with the write byte.
- R3: mem_we_n stays low for exactly PW consecutive cycles in each write.
- R4: The write byte is driven for at least PW+1 cycles before mem_we_n rises. It stays driven and unchanged for HOLD cycles after the rise.
- R5: mem_addr equals the accepted address and does not change on any cycle in which the memory is selected.
- R6: A read holds mem_oe_n=0 and mem_we_n=1 while selected, for WAIT+2 cycles. The byte is sampled at the end of that window, so it has had at least ACC cycles to settle.
- R7: rd_valid is a single-cycle pulse carrying the sampled byte on rd_data. It is high in cycle WAIT+3 counted from the cycle after acceptance.
- R8: After a read the block deselects the memory, keeps mem_oe_n high and leaves the bus undriven for TA cycles, with ready low, before it returns to idle.
- R9: A request is accepted on a clock edge where req and ready are both 1. ready is low from then on: 1+PW+HOLD cycles for a write, WAIT+2+TA cycles for a read.
- R10: The block drives the bus only while mem_oe_n is 1, never while the memory is reading, and never within cyc(T_HZOE) cycles after a read ends.
- R11: Every nonzero nanosecond parameter becomes a cycle count by rounding up, so any nonzero interval costs at least one cycle. Each timed state lasts at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request, taken when ready is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Byte to write |
| ready | output | 1 | Controller idle and able to accept |
| rd_data | output | 8 | Byte returned by the last read |
| rd_valid | output | 1 | One-cycle strobe for rd_data |
| mem_addr | output | 17 | Address pins of the memory |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_o | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Tristate enable for mem_dq_o |
| mem_dq_i | input | 8 | Data returned from the memory bus |

## Verification
The bench builds the block with its default parameters: the fastest speed grade at a 5 ns clock. These give a three-cycle access window with one wait cycle, a two-cycle write strobe, a one-cycle hold and a two-cycle turnaround. Because WAIT, PW and TA are all nonzero, every timed state is entered and its counter path is exercised. The bench's memory model returns a poison byte until its own access count has elapsed, and it flags bus contention through the output-disable window. A controller that samples a cycle early or drives the bus too soon after a read therefore shows up in the results. Address extremes 0 and 0x1FFFF, overwrites, and back-to-back read/write mixes are covered.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ADDR,
    ST_RD_WAIT,
    ST_RD_CAPTURE,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_HOLD,
    ST_TURNAROUND
  } ctrl_state_e;

  // Round a nanosecond interval up to whole clock cycles (R11).
  function automatic int ns_to_cycles(input int t_ns, input int clk_ns);
    if (t_ns <= 0) return 0;
    return (t_ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int access_cycles(input int t_aa, input int t_doe, input int clk_ns);
    return max2(max2(ns_to_cycles(t_aa, clk_ns), ns_to_cycles(t_doe, clk_ns)), 1);
  endfunction

  // Cycles spent in the wait state between address and capture cycles.
  function automatic int read_wait_cycles(input int acc);
    return max2(acc - 2, 0);
  endfunction

  function automatic int turnaround_cycles(input int t_hzoe, input int t_rc,
                                           input int rd_wait, input int clk_ns);
    return max2(max2(ns_to_cycles(t_hzoe, clk_ns), 1),
                ns_to_cycles(t_rc, clk_ns) - rd_wait - 2);
  endfunction

  function automatic int pulse_cycles(input int t_pwe, input int t_sd,
                                      input int t_aw, input int clk_ns);
    return max2(max2(ns_to_cycles(t_pwe, clk_ns), ns_to_cycles(t_sd, clk_ns)),
                max2(ns_to_cycles(t_aw, clk_ns) - 1, 1));
  endfunction

  function automatic int hold_cycles(input int t_hd, input int t_wc,
                                     input int pulse, input int clk_ns);
    return max2(max2(ns_to_cycles(t_hd, clk_ns), 1),
                ns_to_cycles(t_wc, clk_ns) - 1 - pulse);
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               count <= '0;
    else if (load)            count <= load_val;
    else if (count != '0)     count <= count - 1'b1;
  end

  // The last cycle of a loaded interval is the one where count reads 1.
  assign expired = (count <= CNT_W'(1));

  assert_load_nonzero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_val != '0));

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int RD_WAIT_CYC = 1,
  parameter int PULSE_CYC   = 2,
  parameter int HOLD_CYC    = 1,
  parameter int TA_CYC      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             req_write,
  input  logic             tmr_expired,
  output ctrl_state_e      state,
  output logic             accept,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val
);

  ctrl_state_e nxt;

  assign accept = (state == ST_IDLE) && req;

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      ST_IDLE: begin
        if (req) nxt = req_write ? ST_WR_SETUP : ST_RD_ADDR;
      end
      ST_RD_ADDR: begin
        if (RD_WAIT_CYC > 0) begin
          nxt      = ST_RD_WAIT;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(RD_WAIT_CYC);
        end else begin
          nxt = ST_RD_CAPTURE;
        end
      end
      ST_RD_WAIT: begin
        if (tmr_expired) nxt = ST_RD_CAPTURE;
      end
      ST_RD_CAPTURE: begin
        nxt      = ST_TURNAROUND;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(TA_CYC);
      end
      ST_WR_SETUP: begin
        nxt      = ST_WR_PULSE;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(PULSE_CYC);
      end
      ST_WR_PULSE: begin
        if (tmr_expired) begin
          nxt      = ST_WR_HOLD;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(HOLD_CYC);
        end
      end
      ST_WR_HOLD: begin
        if (tmr_expired) nxt = ST_IDLE;
      end
      ST_TURNAROUND: begin
        if (tmr_expired) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (state != ST_IDLE));

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  ctrl_state_e       state,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              in_read;
  logic              in_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  assign in_read  = (state == ST_RD_ADDR) || (state == ST_RD_WAIT) ||
                    (state == ST_RD_CAPTURE);
  assign in_write = (state == ST_WR_SETUP) || (state == ST_WR_PULSE) ||
                    (state == ST_WR_HOLD);

  assign mem_addr  = addr_q;
  assign mem_sel_n = !(in_read || in_write);
  assign mem_sel   = in_read || in_write;
  assign mem_oe_n  = !in_read;
  assign mem_we_n  = (state != ST_WR_PULSE);
  assign mem_dq_oe = in_write;
  assign mem_dq_o  = wdata_q;

  // Sample the bus at the edge that closes the capture cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= (state == ST_RD_CAPTURE);
      if (state == ST_RD_CAPTURE) rd_data <= mem_dq_i;
    end
  end

  assert_bus_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  assert_addr_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_sel_n && $past(!mem_sel_n)) |-> $stable(mem_addr));

  assert_rvalid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int CLK_NS     = 5,
  parameter int T_RC_NS    = 12,
  parameter int T_AA_NS    = 12,
  parameter int T_DOE_NS   = 6,
  parameter int T_HZOE_NS  = 6,
  parameter int T_WC_NS    = 12,
  parameter int T_AW_NS    = 10,
  parameter int T_PWE_NS   = 10,
  parameter int T_SD_NS    = 7,
  parameter int T_HD_NS    = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int ACC_CYC     = access_cycles(T_AA_NS, T_DOE_NS, CLK_NS);
  localparam int RD_WAIT_CYC = read_wait_cycles(ACC_CYC);
  localparam int TA_CYC      = turnaround_cycles(T_HZOE_NS, T_RC_NS, RD_WAIT_CYC, CLK_NS);
  localparam int PULSE_CYC   = pulse_cycles(T_PWE_NS, T_SD_NS, T_AW_NS, CLK_NS);
  localparam int HOLD_CYC    = hold_cycles(T_HD_NS, T_WC_NS, PULSE_CYC, CLK_NS);
  localparam int MAX_CYC     = max2(max2(RD_WAIT_CYC, TA_CYC), max2(PULSE_CYC, HOLD_CYC));
  localparam int CNT_W       = max2($clog2(MAX_CYC + 1), 1);

  ctrl_state_e      state;
  logic             accept;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;

  // Named events for the checks below.
  logic             wr_strobe;
  logic [CNT_W-1:0] we_low_cnt;

  assign ready     = (state == ST_IDLE);
  assign wr_strobe = !mem_we_n;

  sram_ctrl_fsm #(
    .CNT_W       (CNT_W),
    .RD_WAIT_CYC (RD_WAIT_CYC),
    .PULSE_CYC   (PULSE_CYC),
    .HOLD_CYC    (HOLD_CYC),
    .TA_CYC      (TA_CYC)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .req_write   (req_write),
    .tmr_expired (tmr_expired),
    .state       (state),
    .accept      (accept),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val)
  );

  sram_ctrl_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sram_ctrl_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .state     (state),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .mem_dq_i  (mem_dq_i),
    .mem_addr  (mem_addr),
    .mem_sel_n (mem_sel_n),
    .mem_sel   (mem_sel),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

  // Strobe-width monitor: counts consecutive low cycles of mem_we_n.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         we_low_cnt <= '0;
    else if (wr_strobe) we_low_cnt <= we_low_cnt + 1'b1;
    else                we_low_cnt <= '0;
  end

  assert_pulse_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low_cnt == CNT_W'(PULSE_CYC)));

  assert_write_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_dq_o)));

  assert_write_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> (!mem_sel_n && mem_sel && mem_oe_n && mem_dq_oe));

  assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (mem_sel_n && !mem_sel && mem_we_n && mem_oe_n && !mem_dq_oe));

endmodule

// File: tb/sram_async_ctrl_tb.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb;

  localparam int CLK_NS = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        ready;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic [16:0] mem_addr;
  logic        mem_sel_n, mem_sel, mem_we_n, mem_oe_n;
  logic [7:0]  mem_dq_o;
  logic        mem_dq_oe;
  logic [7:0]  mem_dq_i = 8'h5A;

  int tests = 0;
  int fails = 0;
  int contention = 0;
  bit finished = 0;

  // Expected cycle counts, derived from the requirement formulas.
  int b_acc, b_wait, b_ta, b_pw, b_hold, b_hz;

  logic [7:0] model_mem [logic [16:0]];
  logic [7:0] golden    [logic [16:0]];
  int rd_cnt = 0;
  int hz_left = 0;

  always #2.5 clk = ~clk;

  sram_async_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .mem_addr(mem_addr),
    .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i)
  );

  // Smallest cycle count covering t nanoseconds (R11).
  function automatic int cyc_b(int t);
    int n = 0;
    if (t <= 0) return 0;
    while (n * CLK_NS < t) n++;
    return n;
  endfunction

  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  // Memory model: reacts on falling edges, poison until access time elapsed.
  always @(negedge clk) begin
    logic rd_act, wr_act;
    rd_act = !mem_sel_n && mem_sel && !mem_oe_n && mem_we_n;
    wr_act = !mem_sel_n && mem_sel && !mem_we_n;
    if (wr_act && mem_dq_oe) model_mem[mem_addr] = mem_dq_o;
    if (rd_act) begin
      rd_cnt++;
      hz_left = b_hz;
      if (mem_dq_oe) contention++;
      if (rd_cnt >= b_acc)
        mem_dq_i <= model_mem.exists(mem_addr) ? model_mem[mem_addr] : 8'h00;
      else
        mem_dq_i <= 8'hEE;
    end else begin
      rd_cnt = 0;
      if (hz_left > 0 && mem_dq_oe) contention++;
      if (hz_left > 0) hz_left--;
      mem_dq_i <= 8'h5A;
    end
  end

  task automatic check_idle(input string tag);
    check(mem_sel_n && !mem_sel && mem_we_n && mem_oe_n && !mem_dq_oe,
          tag, {mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
    check(ready && !rd_valid, tag, {ready, rd_valid}, 2'b10);
  endtask

  task automatic do_write(input logic [16:0] a, input logic [7:0] d);
    int busy = 0, wl = 0, pre = 0, post = 0;
    bit drv_ok = 1, addr_ok = 1, hold_ok = 1, seen_rise = 0;
    req = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req = 0; req_addr = ~a; req_wdata = ~d;
    while (!ready && busy < 100) begin
      busy++;
      if (!mem_sel_n && mem_addr != a) addr_ok = 0;
      if (!mem_we_n) begin
        wl++;
        if (!(mem_dq_oe && mem_dq_o == d && mem_oe_n)) drv_ok = 0;
      end else if (wl > 0) begin
        seen_rise = 1;
        if (mem_dq_oe && mem_dq_o == d) post++;
        else hold_ok = 0;
      end
      if (wl == 0 && mem_dq_oe && mem_dq_o == d) pre++;
      @(negedge clk);
    end
    golden[a] = d;
    check(busy == 1 + b_pw + b_hold, "R9 write busy", busy, 1 + b_pw + b_hold);
    check(wl == b_pw, "R3 strobe width", wl, b_pw);
    check(drv_ok, "R2 strobe conditions", drv_ok, 1);
    check(pre + wl >= b_pw + 1, "R4 data setup", pre + wl, b_pw + 1);
    check(seen_rise && hold_ok && post == b_hold, "R4 data hold", post, b_hold);
    check(addr_ok, "R5 write address", addr_ok, 1);
    check(model_mem.exists(a) && model_mem[a] == d, "R2 byte stored",
          model_mem.exists(a) ? int'(model_mem[a]) : -1, d);
    check_idle("R1 after write");
  endtask

  task automatic do_read(input logic [16:0] a);
    int busy = 0, rv_idx = 0, rv_cnt = 0, sel_rd = 0;
    bit pin_ok = 1, addr_ok = 1;
    logic [7:0] got = 8'h00;
    logic [7:0] exp;
    exp = golden.exists(a) ? golden[a] : 8'h00;
    req = 1; req_write = 0; req_addr = a; req_wdata = 8'h99;
    @(negedge clk);
    req = 0; req_addr = ~a;
    while (!ready && busy < 100) begin
      busy++;
      if (!mem_sel_n) begin
        sel_rd++;
        if (mem_oe_n || !mem_we_n || mem_dq_oe) pin_ok = 0;
        if (mem_addr != a) addr_ok = 0;
      end
      if (rd_valid) begin
        rv_cnt++;
        if (rv_idx == 0) begin rv_idx = busy; got = rd_data; end
      end
      @(negedge clk);
    end
    check(got == exp, "R7 read data", got, exp);
    check(rv_idx == b_wait + 3, "R7 valid timing", rv_idx, b_wait + 3);
    check(rv_cnt == 1, "R7 single pulse", rv_cnt, 1);
    check(pin_ok && sel_rd == b_wait + 2, "R6 read window", sel_rd, b_wait + 2);
    check(addr_ok, "R5 read address", addr_ok, 1);
    check(busy == b_wait + 2 + b_ta, "R8 turnaround busy", busy, b_wait + 2 + b_ta);
    check_idle("R1 after read");
  endtask

  initial begin
    b_acc  = mx(mx(cyc_b(12), cyc_b(6)), 1);
    b_wait = mx(b_acc - 2, 0);
    b_ta   = mx(mx(cyc_b(6), 1), cyc_b(12) - b_wait - 2);
    b_pw   = mx(mx(cyc_b(10), cyc_b(7)), mx(cyc_b(10) - 1, 1));
    b_hold = mx(mx(cyc_b(0), 1), cyc_b(12) - 1 - b_pw);
    b_hz   = cyc_b(6);
    // R11: rounding rule restated on chosen intervals
    check(cyc_b(7) == 2 && cyc_b(5) == 1 && cyc_b(1) == 1 && cyc_b(0) == 0,
          "R11 rounding", cyc_b(7), 2);

    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    rst_n = 1;
    @(negedge clk);
    check_idle("R1 after reset");

    // Scenario: address extremes
    do_write(17'h00000, 8'h3C);
    do_write(17'h1FFFF, 8'hC3);
    do_read(17'h00000);
    do_read(17'h1FFFF);

    // Scenario: spread patterns
    for (int i = 0; i < 8; i++) do_write(17'(i * 17'h2345), 8'(8'hA0 ^ (i * 37)));
    for (int i = 7; i >= 0; i--) do_read(17'(i * 17'h2345));

    // Scenario: overwrite then read; read-to-write turnaround mix
    do_write(17'h00100, 8'h11);
    do_write(17'h00100, 8'hFE);
    do_read(17'h00100);
    do_write(17'h00101, 8'h00);
    do_read(17'h00101);
    do_read(17'h0BEEF);

    // R10: no contention observed at any point
    check(contention == 0, "R10 bus contention", contention, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule